// File: doc/BRIEF.md
# Dual Calendar Alarm with Power-Enable Control

This block watches a live BCD calendar (seconds up to year, six bytes) and compares it with two alarm sets held in registers. An alarm counts only when all six fields equal the calendar. There is no per-field mask. When a set first matches, the block latches a status flag for it. A flag stays set until software writes 1 to its bit. Each flag, plus a flag for the calendar's periodic tick, can be routed to a registered interrupt line through its own enable bit.

The second alarm also serves as a shutdown timer. If power control is armed, its match drives the external `power_en` output low. `power_en` stays low until a reset, or until one of four external wakeup pins becomes active. Each pin has its own enable bit and its own polarity bit. A registered `wake` output reports an active enabled pin, or the first alarm's flag when alarm wake is allowed. The calendar counter and any pin debouncing sit outside this block. The pins are expected to be synchronous to `clk` already.

Top module: `rtc_dual_alarm`

## Requirements
- R1: After a synchronous reset, all status flags, enables, alarm fields and pin settings are 0, `irq` and `wake` are 0, and `power_en` is 1.
- R2: The alarm fields use byte-wide registers. Alarm A is at 0x20 + 4*k and alarm B at 0x80 + 4*k, where k = 0..5 selects seconds, minutes, hours, day, month, year. `reg_rdata` returns the addressed register one clock after the address is presented.
- R3: Alarm A sets status bit 6 (status at 0x44) on the first cycle in which all six calendar bytes equal its fields. A difference in any single field sets nothing.
- R4: Alarm B sets status bit 7 under the same full-match rule.
- R5: A match is a single event. A calendar that keeps matching does not set the flag again after software has cleared it.
- R6: Status flags are cleared by writing 1 to their bit. Writing 0 leaves them unchanged. A set event in the same cycle as a clear wins.
- R7: The interrupt-enable register at 0x48 has three enables: bit 2 for the tick flag, bit 3 for the alarm A flag and bit 4 for the alarm B flag. `irq` goes high one clock after any enabled flag is set, and falls one clock after the last enabled flag clears.
- R8: A one-cycle pulse on `tick_evt` sets status bit 2.
- R9: The power-control register is at 0x98. If its bit 16 is set, an alarm B match drives `power_en` low on the same clock edge that sets status bit 7. If bit 16 is clear, `power_en` stays high.
- R10: Power-control bits 0..3 enable wakeup pins 0..3, and bits 4..7 set their polarity (1 = active low). An active, enabled pin returns `power_en` high. A pin that is not enabled has no effect.
- R11: `wake` is registered. It is high when any enabled pin is active, or when alarm A's flag is set and bit 1 of the wake-enable register at 0x7C is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cal_bcd | input | 48 | Live calendar, byte k = field k (seconds in bits 7:0, year in bits 47:40) |
| tick_evt | input | 1 | One-cycle periodic tick from the calendar |
| ext_wake | input | 4 | External wakeup pins, already synchronous |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data for `reg_addr` |
| irq | output | 1 | Registered interrupt request |
| wake | output | 1 | Registered wake request |
| power_en | output | 1 | External power enable, high = on |

## Verification
The bound checker checks the following on every cycle:
- The reset values of the outputs.
- That each match event sets its flag one clock later.
- That a flag only rises after a match event.
- That `irq` follows an enabled flag.
- That every fall of `power_en` comes from an armed alarm B event.
- That every rise of `power_en` outside reset comes from an active enabled pin.

Only the directed scenarios can show the rest:
- Single-field mismatches.
- That a cleared flag is not set again by a calendar that keeps matching.
- Write-0 versus write-1 clearing.
- Ignoring a disabled pin.
- The two polarity settings.

// File: rtl/rtc_alm_pkg.sv
package rtc_alm_pkg;
  // register byte addresses
  localparam int ALM_A_BASE = 'h20;
  localparam int ALM_B_BASE = 'h80;
  localparam int FIELD_STEP = 4;
  localparam int STAT_ADDR  = 'h44;
  localparam int IEN_ADDR   = 'h48;
  localparam int WEN_ADDR   = 'h7C;
  localparam int PWR_ADDR   = 'h98;
  // status bits
  localparam int ST_TICK = 2;
  localparam int ST_A    = 6;
  localparam int ST_B    = 7;
  // interrupt enable bits
  localparam int IE_TICK = 2;
  localparam int IE_A    = 3;
  localparam int IE_B    = 4;
  // wake enable bit for alarm A
  localparam int WEN_A   = 1;
  // power control
  localparam int PWR_ARM = 16;
  localparam int POL_LSB = 4;
endpackage

// File: rtl/rtc_alm_match.sv
module rtc_alm_match #(
  parameter int FW = 8,
  parameter int NF = 6
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NF*FW-1:0] alm,
  input  logic [NF*FW-1:0] cal,
  output logic            evt
);
  localparam int TOTW = NF * FW;

  logic [NF-1:0] fld_eq;
  logic          hit, hit_q;

  for (genvar k = 0; k < NF; k++) begin : g_fld
    assign fld_eq[k] = (alm[k*FW +: FW] == cal[k*FW +: FW]);
  end

  assign hit = &fld_eq;

  always_ff @(posedge clk) begin
    if (rst) hit_q <= 1'b0;
    else     hit_q <= hit;
  end

  // first cycle of equality only
  assign evt = hit & ~hit_q;

  logic unused_w;
  assign unused_w = ^TOTW;
endmodule

// File: rtl/rtc_wake_pwr.sv
module rtc_wake_pwr #(
  parameter int NP = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NP-1:0] pins,
  input  logic [NP-1:0] pin_en,
  input  logic [NP-1:0] pin_pol,
  input  logic          b_evt,
  input  logic          pwr_arm,
  input  logic          a_flag,
  input  logic          a_wake_en,
  output logic [NP-1:0] pin_act,
  output logic          power_en,
  output logic          wake
);
  // polarity 1 = active low
  assign pin_act = pin_en & (pins ^ pin_pol);

  always_ff @(posedge clk) begin
    if (rst) begin
      power_en <= 1'b1;
      wake     <= 1'b0;
    end else begin
      if (b_evt && pwr_arm)  power_en <= 1'b0;
      else if (|pin_act)     power_en <= 1'b1;
      wake <= (a_flag & a_wake_en) | (|pin_act);
    end
  end
endmodule

// File: rtl/rtc_dual_alarm.sv
module rtc_dual_alarm
  import rtc_alm_pkg::*;
#(
  parameter int FW = 8,
  parameter int NF = 6,
  parameter int NP = 4,
  parameter int AW = 8,
  parameter int DW = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NF*FW-1:0] cal_bcd,
  input  logic             tick_evt,
  input  logic [NP-1:0]    ext_wake,
  input  logic             reg_we,
  input  logic [AW-1:0]    reg_addr,
  input  logic [DW-1:0]    reg_wdata,
  output logic [DW-1:0]    reg_rdata,
  output logic             irq,
  output logic             wake,
  output logic             power_en
);
  localparam int NALM = 2;

  logic [NALM-1:0][NF-1:0][FW-1:0] alm_q;
  logic [NALM-1:0]                 alm_evt;
  logic                            st_tick, st_a, st_b;
  logic [2:0]                      ie_q;
  logic                            wen_q;
  logic [NP-1:0]                   pen_q, ppol_q;
  logic                            parm_q;
  logic [NP-1:0]                   pin_act;

  logic wr_stat, wr_ien, wr_wen, wr_pwr;
  assign wr_stat = reg_we && (reg_addr == AW'(STAT_ADDR));
  assign wr_ien  = reg_we && (reg_addr == AW'(IEN_ADDR));
  assign wr_wen  = reg_we && (reg_addr == AW'(WEN_ADDR));
  assign wr_pwr  = reg_we && (reg_addr == AW'(PWR_ADDR));

  // alarm field storage and comparators
  for (genvar g = 0; g < NALM; g++) begin : g_alm
    localparam int BASE = (g == 0) ? ALM_A_BASE : ALM_B_BASE;
    for (genvar k = 0; k < NF; k++) begin : g_f
      always_ff @(posedge clk) begin
        if (rst) alm_q[g][k] <= '0;
        else if (reg_we && reg_addr == AW'(BASE + FIELD_STEP * k))
          alm_q[g][k] <= reg_wdata[FW-1:0];
      end
    end
    rtc_alm_match #(.FW(FW), .NF(NF)) u_match (
      .clk (clk),
      .rst (rst),
      .alm (alm_q[g]),
      .cal (cal_bcd),
      .evt (alm_evt[g])
    );
  end

  // status flags: set wins over write-1-clear
  always_ff @(posedge clk) begin
    if (rst) begin
      st_tick <= 1'b0;
      st_a    <= 1'b0;
      st_b    <= 1'b0;
    end else begin
      st_tick <= tick_evt   | (st_tick & ~(wr_stat & reg_wdata[ST_TICK]));
      st_a    <= alm_evt[0] | (st_a    & ~(wr_stat & reg_wdata[ST_A]));
      st_b    <= alm_evt[1] | (st_b    & ~(wr_stat & reg_wdata[ST_B]));
    end
  end

  // control registers
  always_ff @(posedge clk) begin
    if (rst) begin
      ie_q   <= '0;
      wen_q  <= 1'b0;
      pen_q  <= '0;
      ppol_q <= '0;
      parm_q <= 1'b0;
    end else begin
      if (wr_ien) ie_q  <= {reg_wdata[IE_B], reg_wdata[IE_A], reg_wdata[IE_TICK]};
      if (wr_wen) wen_q <= reg_wdata[WEN_A];
      if (wr_pwr) begin
        pen_q  <= reg_wdata[NP-1:0];
        ppol_q <= reg_wdata[POL_LSB +: NP];
        parm_q <= reg_wdata[PWR_ARM];
      end
    end
  end

  // interrupt
  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= (st_tick & ie_q[0]) | (st_a & ie_q[1]) | (st_b & ie_q[2]);
  end

  rtc_wake_pwr #(.NP(NP)) u_wake (
    .clk       (clk),
    .rst       (rst),
    .pins      (ext_wake),
    .pin_en    (pen_q),
    .pin_pol   (ppol_q),
    .b_evt     (alm_evt[1]),
    .pwr_arm   (parm_q),
    .a_flag    (st_a),
    .a_wake_en (wen_q),
    .pin_act   (pin_act),
    .power_en  (power_en),
    .wake      (wake)
  );

  // read mux
  logic [DW-1:0] rd_d;
  always_comb begin
    rd_d = '0;
    if (reg_addr == AW'(STAT_ADDR)) begin
      rd_d[ST_TICK] = st_tick;
      rd_d[ST_A]    = st_a;
      rd_d[ST_B]    = st_b;
    end else if (reg_addr == AW'(IEN_ADDR)) begin
      rd_d[IE_TICK] = ie_q[0];
      rd_d[IE_A]    = ie_q[1];
      rd_d[IE_B]    = ie_q[2];
    end else if (reg_addr == AW'(WEN_ADDR)) begin
      rd_d[WEN_A] = wen_q;
    end else if (reg_addr == AW'(PWR_ADDR)) begin
      rd_d[NP-1:0]          = pen_q;
      rd_d[POL_LSB +: NP]   = ppol_q;
      rd_d[PWR_ARM]         = parm_q;
    end
    for (int g = 0; g < NALM; g++) begin
      for (int k = 0; k < NF; k++) begin
        if (reg_addr == AW'(((g == 0) ? ALM_A_BASE : ALM_B_BASE) + FIELD_STEP * k))
          rd_d[FW-1:0] = alm_q[g][k];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else     reg_rdata <= rd_d;
  end
endmodule

// File: rtl/rtc_dual_alarm_chk.sv
module rtc_dual_alarm_chk #(
  parameter int NP = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          irq,
  input logic          wake,
  input logic          power_en,
  input logic [1:0]    alm_evt,
  input logic          st_tick,
  input logic          st_a,
  input logic          st_b,
  input logic [2:0]    ie_q,
  input logic          parm_q,
  input logic [NP-1:0] pin_act
);
  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (power_en && !irq && !wake && !st_a && !st_b && !st_tick));

  // R3
  a_flag_set_chk: assert property (@(posedge clk) disable iff (rst)
    alm_evt[0] |=> st_a);

  // R4
  b_flag_set_chk: assert property (@(posedge clk) disable iff (rst)
    alm_evt[1] |=> st_b);

  // R5
  a_flag_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(st_a) |-> $past(alm_evt[0]));

  // R7
  irq_follow_chk: assert property (@(posedge clk) disable iff (rst)
    ((st_tick && ie_q[0]) || (st_a && ie_q[1]) || (st_b && ie_q[2])) |=> irq);

  // R9
  pwr_off_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(power_en) |-> $past(alm_evt[1] && parm_q));

  // R10
  pwr_on_cause_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(power_en) && !$past(rst)) |-> $past(|pin_act));
endmodule

bind rtc_dual_alarm rtc_dual_alarm_chk #(.NP(NP)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .irq      (irq),
  .wake     (wake),
  .power_en (power_en),
  .alm_evt  (alm_evt),
  .st_tick  (st_tick),
  .st_a     (st_a),
  .st_b     (st_b),
  .ie_q     (ie_q),
  .parm_q   (parm_q),
  .pin_act  (pin_act)
);

// File: tb/sim_rtc_dual_alarm.sv
module sim_rtc_dual_alarm;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [47:0] cal_bcd;
  logic        tick_evt = 1'b0;
  logic [3:0]  ext_wake = 4'hF;
  logic        reg_we = 1'b0;
  logic [7:0]  reg_addr = 8'h00;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq, wake, power_en;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // fields: {year, month, day, hour, min, sec}
  localparam logic [47:0] CAL0 = {8'h23, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00};
  localparam logic [47:0] ALA  = {8'h24, 8'h06, 8'h21, 8'h12, 8'h15, 8'h30};
  localparam logic [47:0] ALB  = {8'h25, 8'h01, 8'h01, 8'h08, 8'h00, 8'h05};

  always #5 clk = ~clk;

  rtc_dual_alarm u0 (
    .clk(clk), .rst(rst), .cal_bcd(cal_bcd), .tick_evt(tick_evt),
    .ext_wake(ext_wake), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .wake(wake), .power_en(power_en)
  );

  initial cal_bcd = CAL0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic set_cal(input logic [47:0] v);
    @(negedge clk);
    cal_bcd = v;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    chk("R1 power_en", 32'(power_en), 1);
    chk("R1 irq", 32'(irq), 0);
    chk("R1 wake", 32'(wake), 0);
    rd(8'h44, d); chk("R1 status", d, 0);
    rd(8'h20, d); chk("R1 alarm field", d, 0);
    rd(8'h98, d); chk("R1 power ctl", d, 0);
  endtask

  task automatic t_regs;
    logic [31:0] d;
    for (int k = 0; k < 6; k++) begin
      wr(8'(8'h20 + 4 * k), 32'(ALA[8*k +: 8]));
      wr(8'(8'h80 + 4 * k), 32'(ALB[8*k +: 8]));
    end
    for (int k = 0; k < 6; k++) begin
      rd(8'(8'h20 + 4 * k), d); chk("R2 alarm A readback", d, 32'(ALA[8*k +: 8]));
      rd(8'(8'h80 + 4 * k), d); chk("R2 alarm B readback", d, 32'(ALB[8*k +: 8]));
    end
  endtask

  task automatic t_alarm_a;
    logic [31:0] d;
    set_cal({ALA[47:8], 8'h29});
    repeat (3) @(negedge clk);
    rd(8'h44, d); chk("R3 seconds mismatch", d, 0);
    set_cal({8'h23, ALA[39:0]});
    repeat (3) @(negedge clk);
    rd(8'h44, d); chk("R3 year mismatch", d, 0);
    set_cal(ALA);
    rd(8'h44, d); chk("R3 full match", d, 32'h40);
    chk("R7 irq masked", 32'(irq), 0);
    wr(8'h44, 32'h40);
    repeat (3) @(negedge clk);
    rd(8'h44, d); chk("R5 no re-set while equal", d, 0);
    wr(8'h48, 32'h08);
    set_cal(CAL0);
    set_cal(ALA);
    rd(8'h44, d); chk("R3 second match", d, 32'h40);
    chk("R7 irq alarm A", 32'(irq), 1);
    wr(8'h44, 32'h00);
    rd(8'h44, d); chk("R6 write 0 keeps flag", d, 32'h40);
    wr(8'h44, 32'h40);
    @(negedge clk);
    chk("R7 irq falls", 32'(irq), 0);
    rd(8'h44, d); chk("R6 write 1 clears", d, 0);
    wr(8'h48, 32'h00);
    set_cal(CAL0);
  endtask

  task automatic t_tick;
    logic [31:0] d;
    wr(8'h48, 32'h04);
    @(negedge clk); tick_evt = 1'b1;
    @(negedge clk); tick_evt = 1'b0;
    @(negedge clk);
    chk("R7 irq tick", 32'(irq), 1);
    rd(8'h44, d); chk("R8 tick flag", d, 32'h04);
    wr(8'h44, 32'h04);
    wr(8'h48, 32'h00);
  endtask

  task automatic t_wake_alarm;
    logic [31:0] d;
    wr(8'h7C, 32'h02);
    rd(8'h7C, d); chk("R11 wake enable readback", d, 32'h02);
    set_cal(ALA);
    @(negedge clk);
    @(negedge clk);
    chk("R11 wake on alarm A", 32'(wake), 1);
    wr(8'h44, 32'h40);
    @(negedge clk);
    chk("R11 wake drops", 32'(wake), 0);
    wr(8'h7C, 32'h00);
    set_cal(CAL0);
  endtask

  task automatic t_b_unarmed;
    logic [31:0] d;
    set_cal(ALB);
    @(negedge clk);
    chk("R9 unarmed power_en", 32'(power_en), 1);
    rd(8'h44, d); chk("R4 alarm B flag", d, 32'h80);
    wr(8'h44, 32'h80);
    set_cal(CAL0);
  endtask

  task automatic t_shutdown;
    logic [31:0] d;
    wr(8'h98, 32'h0001_0011);
    rd(8'h98, d); chk("R2 power ctl readback", d, 32'h0001_0011);
    set_cal(ALB);
    @(negedge clk);
    chk("R9 power_en off", 32'(power_en), 0);
    rd(8'h44, d); chk("R4 alarm B flag armed", d, 32'h80);
    ext_wake = 4'hD;
    @(negedge clk); @(negedge clk);
    chk("R10 disabled pin ignored", 32'(power_en), 0);
    chk("R11 disabled pin no wake", 32'(wake), 0);
    ext_wake = 4'hE;
    @(negedge clk);
    chk("R10 active-low pin restores", 32'(power_en), 1);
    chk("R11 wake from pin", 32'(wake), 1);
    ext_wake = 4'hF;
    @(negedge clk);
    chk("R11 wake idle", 32'(wake), 0);
    wr(8'h98, 32'h0000_0004);
    @(negedge clk);
    chk("R10 active-high pin wake", 32'(wake), 1);
    ext_wake = 4'hB;
    @(negedge clk);
    chk("R10 active-high pin released", 32'(wake), 0);
    wr(8'h44, 32'h80);
    set_cal(CAL0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset;
    t_regs;
    t_alarm_a;
    t_tick;
    t_wake_alarm;
    t_b_unarmed;
    t_shutdown;
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule